// File: doc/BRIEF.md
# Filtered Dual-Edge Input Capture Unit

This block timestamps transitions of one external input against a shared 16-bit free-running tick counter. The raw input first crosses into the clock domain through a two-stage synchroniser. A digital filter then accepts a new level only after a programmable number of consecutive samples agree with it, so short glitches never reach the capture logic.

Two capture channels listen to the same filtered input. Each channel has its own edge selection, a capture register, a capture flag, an overcapture flag, a count of counter wraps since its previous capture, and an optional wrap-corrected tick delta. A common setup puts rising edges on channel A and falling edges on channel B. The period then comes from consecutive captures on one channel, and the high time comes from B minus A.

A one-cycle read strobe per channel tells the unit that software has consumed the value. The strobe clears that channel's capture and overcapture flags.

Top module: `ecap_unit`

## Requirements
- R1: `count_o` starts at 0 after reset, rises by one on every clock, and wraps from 65535 to 0.
- R2: The filter accepts a new input level only after max(`filt_len`,1) consecutive synchronised samples show it. A pulse shorter than that is ignored and causes no capture.
- R3: An accepted edge latches the counter into the capture register of every channel whose selection matches that edge. If `count_o` reads v in the cycle in which `sig_in` changes, the captured value is v + 2 + max(`filt_len`,1) − 1 = v + 1 + max(`filt_len`,1), modulo 65536.
- R4: The edge selection encoding is as follows. Bit 0 enables rising edges and bit 1 enables falling edges. 2'b00 captures nothing and 2'b11 captures both edges.
- R5: A capture sets the channel flag. A one-cycle read strobe clears the flag. A read strobe in the same cycle as a capture leaves the flag set.
- R6: A capture while the flag is still set, with no read in that cycle, sets the overcapture flag and overwrites the register with the newer value. A read strobe clears the overcapture flag.
- R7: On each capture, `wraps_*_o` shows how many times the counter wrapped between the channel's previous capture (or reset) and this one, saturating at its maximum.
- R8: On each capture, `delta_*_o` equals wraps × 65536 + new capture − previous capture as a 32-bit value. The previous capture is 0 after reset.
- R9: With rising edges on A and falling edges on B, `cap_b_o − cap_a_o` equals the high time of `sig_in` in clock cycles.
- R10: While reset is asserted, the counter, capture registers, flags, wrap counts and deltas all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous input to timestamp |
| filt_len | input | 4 | Required count of agreeing samples (0 acts as 1) |
| edge_sel_a | input | 2 | Channel A edge selection |
| edge_sel_b | input | 2 | Channel B edge selection |
| rd_a | input | 1 | Channel A read strobe |
| rd_b | input | 1 | Channel B read strobe |
| count_o | output | 16 | Free-running counter |
| cap_a_o | output | 16 | Channel A captured value |
| flag_a_o | output | 1 | Channel A capture flag |
| ovr_a_o | output | 1 | Channel A overcapture flag |
| wraps_a_o | output | 16 | Channel A wraps between its last two captures |
| delta_a_o | output | 32 | Channel A wrap-corrected delta |
| cap_b_o | output | 16 | Channel B captured value |
| flag_b_o | output | 1 | Channel B capture flag |
| ovr_b_o | output | 1 | Channel B overcapture flag |
| wraps_b_o | output | 16 | Channel B wraps between its last two captures |
| delta_b_o | output | 32 | Channel B wrap-corrected delta |

## Verification
The hardest cases to reach are a read strobe landing in exactly the cycle of a capture, and a capture gap that spans a counter wrap. For the first, the stimulus derives the capture edge from the known synchroniser-plus-filter latency and raises the strobe one cycle ahead of it. For the second, it holds the input steady for about seventy thousand cycles and predicts the wrap count and delta from its own cycle tally. A sweep over filter lengths and pulse widths covers glitch rejection at one sample below and exactly at the threshold.

// File: rtl/ecap_pkg.sv
// Shared definitions for the input capture unit.
// Assumes: edge selections arrive as two-bit codes matching edge_sel_e.
package ecap_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;
    localparam int NUM_CH = 2;
endpackage

// File: rtl/ecap_counter.sv
// Free-running tick counter with a wrap indication.
// Assumes: the counter never stops; wrap_o marks the cycle holding the max value.
module ecap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Advance the counter every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_o <= '0;
        else        cnt_o <= cnt_o + 1'b1;
    end

    // Next edge moves max to zero.
    assign wrap_o = (cnt_o == CNT_MAX);

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/ecap_filter.sv
// Synchroniser plus N-sample agreement filter with edge pulses.
// Assumes: len of 0 is treated as 1; rise/fall pulse in the cycle the level is accepted.
module ecap_filter #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [LEN_W-1:0] len,
    output logic             lvl_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [1:0]       sync_q;
    logic [LEN_W-1:0] run_q;
    logic [LEN_W:0]   need;
    logic [LEN_W:0]   nxt_run;
    logic             differ;
    logic             accept;

    // Two-flop synchroniser for the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], din};
    end

    // Decide whether this sample completes the agreement run.
    always_comb begin
        need    = (len == '0) ? (LEN_W+1)'(1) : {1'b0, len};
        nxt_run = {1'b0, run_q} + (LEN_W+1)'(1);
        differ  = (sync_q[1] != lvl_o);
        accept  = differ && (nxt_run >= need);
    end

    // Track the accepted level and the count of disagreeing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o <= 1'b0;
            run_q <= '0;
        end else if (!differ) begin
            run_q <= '0;
        end else if (accept) begin
            lvl_o <= sync_q[1];
            run_q <= '0;
        end else begin
            run_q <= nxt_run[LEN_W-1:0];
        end
    end

    assign rise_o = accept &  sync_q[1];
    assign fall_o = accept & ~sync_q[1];

    assert_rise_needs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_o) |-> $past(sync_q[1]));
    assert_fall_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl_o) |-> !$past(sync_q[1]));
    assert_edge_moves_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> lvl_o);
endmodule

// File: rtl/ecap_channel.sv
// One capture channel: register, flags, wrap tally and optional delta.
// Assumes: rd is a one-cycle strobe; wrap pulses in the cycle holding the counter max.
module ecap_channel
    import ecap_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int WRAP_W    = 16,
    parameter bit HAS_DELTA = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              sel,
    input  logic                    rise,
    input  logic                    fall,
    input  logic [CNT_W-1:0]        cnt,
    input  logic                    wrap,
    input  logic                    rd,
    output logic [CNT_W-1:0]        cap_o,
    output logic                    flag_o,
    output logic                    ovr_o,
    output logic [WRAP_W-1:0]       wraps_o,
    output logic [CNT_W+WRAP_W-1:0] delta_o
);
    localparam int               DELTA_W  = CNT_W + WRAP_W;
    localparam logic [WRAP_W-1:0] WRAP_MAX = '1;

    edge_sel_e        mode;
    logic             hit;
    logic [WRAP_W-1:0] run_q;

    // Match the filtered edge against this channel's selection.
    always_comb begin
        mode = edge_sel_e'(sel);
        hit  = (rise && (mode == EDGE_RISE || mode == EDGE_BOTH))
            || (fall && (mode == EDGE_FALL || mode == EDGE_BOTH));
    end

    // Latch the counter on a matching edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_o <= '0;
        else if (hit) cap_o <= cnt;
    end

    // Maintain capture and overcapture flags against the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else if (hit) begin
            flag_o <= 1'b1;
            ovr_o  <= rd ? 1'b0 : (ovr_o | flag_o);
        end else if (rd) begin
            flag_o <= 1'b0;
            ovr_o  <= 1'b0;
        end
    end

    // Count wraps since the last capture and publish them at each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            wraps_o <= '0;
        end else if (hit) begin
            wraps_o <= run_q;
            run_q   <= wrap ? WRAP_W'(1) : '0;
        end else if (wrap && run_q != WRAP_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    generate
        if (HAS_DELTA) begin : g_delta
            // Wrap-corrected distance between consecutive captures.
            always_ff @(posedge clk) begin
                if (!rst_n)   delta_o <= '0;
                else if (hit) delta_o <= {run_q, {CNT_W{1'b0}}} + DELTA_W'(cnt) - DELTA_W'(cap_o);
            end
        end else begin : g_no_delta
            assign delta_o = '0;
        end
    endgenerate

    assert_flag_after_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_o);
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit) |=> (!flag_o && !ovr_o));
    assert_ovr_implies_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> flag_o);
    assert_cap_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap_o));
endmodule

// File: rtl/ecap_unit.sv
// Top: shared counter, input filter and two capture channels on one input.
// Assumes: sig_in is asynchronous; software reads pulse rd_* for one cycle.
module ecap_unit
    import ecap_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int LEN_W     = 4,
    parameter int WRAP_W    = 16,
    parameter bit HAS_DELTA = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sig_in,
    input  logic [LEN_W-1:0]        filt_len,
    input  logic [1:0]              edge_sel_a,
    input  logic [1:0]              edge_sel_b,
    input  logic                    rd_a,
    input  logic                    rd_b,
    output logic [CNT_W-1:0]        count_o,
    output logic [CNT_W-1:0]        cap_a_o,
    output logic                    flag_a_o,
    output logic                    ovr_a_o,
    output logic [WRAP_W-1:0]       wraps_a_o,
    output logic [CNT_W+WRAP_W-1:0] delta_a_o,
    output logic [CNT_W-1:0]        cap_b_o,
    output logic                    flag_b_o,
    output logic                    ovr_b_o,
    output logic [WRAP_W-1:0]       wraps_b_o,
    output logic [CNT_W+WRAP_W-1:0] delta_b_o
);
    localparam int DELTA_W = CNT_W + WRAP_W;

    logic                wrap;
    logic                lvl, rise, fall;
    logic [1:0]          sel_v   [NUM_CH];
    logic                rd_v    [NUM_CH];
    logic [CNT_W-1:0]    cap_v   [NUM_CH];
    logic                flag_v  [NUM_CH];
    logic                ovr_v   [NUM_CH];
    logic [WRAP_W-1:0]   wraps_v [NUM_CH];
    logic [DELTA_W-1:0]  delta_v [NUM_CH];

    ecap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_o(count_o), .wrap_o(wrap)
    );

    ecap_filter #(.LEN_W(LEN_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .din(sig_in), .len(filt_len),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    // Gather per-channel controls into arrays.
    always_comb begin
        sel_v[0] = edge_sel_a;
        sel_v[1] = edge_sel_b;
        rd_v[0]  = rd_a;
        rd_v[1]  = rd_b;
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            ecap_channel #(.CNT_W(CNT_W), .WRAP_W(WRAP_W), .HAS_DELTA(HAS_DELTA)) u_ch (
                .clk(clk), .rst_n(rst_n), .sel(sel_v[ch]), .rise(rise), .fall(fall),
                .cnt(count_o), .wrap(wrap), .rd(rd_v[ch]),
                .cap_o(cap_v[ch]), .flag_o(flag_v[ch]), .ovr_o(ovr_v[ch]),
                .wraps_o(wraps_v[ch]), .delta_o(delta_v[ch])
            );
        end
    endgenerate

    assign cap_a_o   = cap_v[0];
    assign flag_a_o  = flag_v[0];
    assign ovr_a_o   = ovr_v[0];
    assign wraps_a_o = wraps_v[0];
    assign delta_a_o = delta_v[0];
    assign cap_b_o   = cap_v[1];
    assign flag_b_o  = flag_v[1];
    assign ovr_b_o   = ovr_v[1];
    assign wraps_b_o = wraps_v[1];
    assign delta_b_o = delta_v[1];

    assert_edge_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));
    assert_level_tracks_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !fall) |=> $stable(lvl));
endmodule

// File: tb/tb_ecap_unit.sv
module tb_ecap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic [3:0]  filt_len = 4'd1;
    logic [1:0]  edge_sel_a = 2'b01;
    logic [1:0]  edge_sel_b = 2'b10;
    logic        rd_a = 1'b0;
    logic        rd_b = 1'b0;
    logic [15:0] count_o, cap_a_o, cap_b_o, wraps_a_o, wraps_b_o;
    logic        flag_a_o, ovr_a_o, flag_b_o, ovr_b_o;
    logic [31:0] delta_a_o, delta_b_o;

    int          checks = 0;
    int          errors = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;

    ecap_unit dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .filt_len(filt_len),
        .edge_sel_a(edge_sel_a), .edge_sel_b(edge_sel_b), .rd_a(rd_a), .rd_b(rd_b),
        .count_o(count_o),
        .cap_a_o(cap_a_o), .flag_a_o(flag_a_o), .ovr_a_o(ovr_a_o),
        .wraps_a_o(wraps_a_o), .delta_a_o(delta_a_o),
        .cap_b_o(cap_b_o), .flag_b_o(flag_b_o), .ovr_b_o(ovr_b_o),
        .wraps_b_o(wraps_b_o), .delta_b_o(delta_b_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lpf(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    task automatic read_ch(input bit a, input bit b);
        @(negedge clk); rd_a = a; rd_b = b;
        @(negedge clk); rd_a = 1'b0; rd_b = 1'b0;
    endtask

    // Drive one level change and wait for the capture; returns the predicted value.
    task automatic edge_cap(input bit lvl, input int lp, output logic [15:0] expv);
        logic [15:0] v;
        @(negedge clk);
        v = count_o;
        sig_in = lvl;
        expv = 16'(v + 1 + lp);
        repeat (lp + 2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] e1, e2, c1, prev_a;
        int unsigned d1, d2, el;
        int lp;

        // R10: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10 count", 32'(count_o), 0);
        chk("R10 cap_a", 32'(cap_a_o), 0);
        chk("R10 flags", {28'd0, flag_a_o, ovr_a_o, flag_b_o, ovr_b_o}, 0);
        chk("R10 delta", delta_a_o | delta_b_o, 0);
        rst_n = 1'b1;

        // R1: counter steps by one
        @(negedge clk); e1 = count_o;
        @(negedge clk); chk("R1 step", 32'(count_o), 32'(16'(e1 + 1)));
        repeat (6) @(negedge clk);
        chk("R1 step8", 32'(count_o), 32'(16'(e1 + 7)));

        // R3/R9/R8: sweep filter lengths and high times, A rising and B falling
        prev_a = 16'd0;
        for (int l = 0; l <= 5; l++) begin
            filt_len = 4'(l);
            lp = lpf(l);
            edge_cap(1'b1, lp, e1);
            chk("R3 cap_a", 32'(cap_a_o), 32'(e1));
            chk("R5 flag_a", 32'(flag_a_o), 1);
            chk("R4 flag_b idle on rise", 32'(flag_b_o), 0);
            chk("R8 delta_a", delta_a_o, 32'(16'(e1 - prev_a)));
            chk("R7 wraps_a", 32'(wraps_a_o), 0);
            prev_a = e1;
            repeat (2 * l) @(negedge clk);
            edge_cap(1'b0, lp, e2);
            chk("R3 cap_b", 32'(cap_b_o), 32'(e2));
            chk("R9 width", 32'(16'(cap_b_o - cap_a_o)), 32'(16'(e2 - e1)));
            read_ch(1'b1, 1'b1);
            chk("R5 read clears", {30'd0, flag_a_o, flag_b_o}, 0);
            repeat (3) @(negedge clk);
        end

        // R2: glitch below threshold ignored, pulse at threshold accepted
        filt_len = 4'd4;
        for (int k = 1; k <= 4; k++) begin
            c1 = cap_a_o;
            @(negedge clk); sig_in = 1'b1;
            repeat (k) @(negedge clk);
            sig_in = 1'b0;
            repeat (12) @(negedge clk);
            if (k < 4) begin
                chk("R2 glitch no flag", 32'(flag_a_o), 0);
                chk("R2 glitch cap kept", 32'(cap_a_o), 32'(c1));
            end else begin
                chk("R2 threshold accepted", 32'(flag_a_o), 1);
            end
        end
        read_ch(1'b1, 1'b1);
        prev_a = cap_a_o;

        // R4: both edges on A, nothing on B
        filt_len = 4'd1;
        edge_sel_a = 2'b11; edge_sel_b = 2'b00;
        c1 = cap_b_o;
        edge_cap(1'b1, 1, e1);
        chk("R4 both rise", 32'(cap_a_o), 32'(e1));
        read_ch(1'b1, 1'b0);
        edge_cap(1'b0, 1, e2);
        chk("R4 both fall", 32'(cap_a_o), 32'(e2));
        chk("R4 none flag_b", 32'(flag_b_o), 0);
        chk("R4 none cap_b", 32'(cap_b_o), 32'(c1));

        // R6: overcapture on a second rise without read
        edge_sel_a = 2'b01;
        edge_cap(1'b1, 1, e1);
        repeat (3) @(negedge clk); sig_in = 1'b0;
        repeat (5) @(negedge clk);
        edge_cap(1'b1, 1, e2);
        chk("R6 ovr set", 32'(ovr_a_o), 1);
        chk("R6 newer value", 32'(cap_a_o), 32'(e2));
        repeat (3) @(negedge clk); sig_in = 1'b0;
        repeat (5) @(negedge clk);

        // R5: read strobe coincides with capture edge
        @(negedge clk);
        e1 = 16'(count_o + 2);
        sig_in = 1'b1;
        repeat (2) @(negedge clk);
        rd_a = 1'b1;
        @(negedge clk); rd_a = 1'b0;
        chk("R5 same-cycle flag", 32'(flag_a_o), 1);
        chk("R6 same-cycle ovr cleared", 32'(ovr_a_o), 0);
        chk("R3 same-cycle cap", 32'(cap_a_o), 32'(e1));
        read_ch(1'b1, 1'b0);
        repeat (3) @(negedge clk); sig_in = 1'b0;
        repeat (5) @(negedge clk);

        // R7/R8/R1: capture gap spanning a counter wrap
        edge_cap(1'b1, 1, e1);
        d1 = cyc;
        c1 = cap_a_o;
        read_ch(1'b1, 1'b0);
        repeat (100) @(negedge clk); sig_in = 1'b0;
        repeat (70000) @(negedge clk);
        @(negedge clk);
        d2 = cyc;
        el = d2 - (d1 - 3);
        chk("R1 wrap count", 32'(count_o), 32'(16'(e1 - 2 + el)));
        e2 = 16'(count_o + 2);
        sig_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 cap after wrap", 32'(cap_a_o), 32'(e2));
        chk("R7 wraps", 32'(wraps_a_o), (32'(c1) + el) >> 16);
        chk("R8 delta", delta_a_o, el);
        chk("R6 no ovr after read", 32'(ovr_a_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule